// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. After a start pulse it first holds the external integrator in its cleared state for a fixed number of clocks. It then connects the unknown input to the integrator for a fixed run-up time. Next it switches the integrator over to a reference of opposite polarity and counts clock cycles until the external comparator reports that the integrator output is back at zero.

The run-down count is the conversion result. It is presented together with a one-cycle valid strobe. The run-up length is a parameter. A longer run-up gives finer resolution at the cost of conversion time. The counter and the result width follow from the run-up length.

The comparator is asynchronous to the converter clock, so its output is resynchronized before use. If the comparator never reports a zero crossing within twice the run-up length, the conversion ends with a saturated result and an overrange flag.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `int_clr_o`, `sel_in_o`, `sel_ref_o`, `valid_o` and `ovr_o` are low and `result_o` is 0.
- R2: A start pulse sampled while idle raises `int_clr_o` from the next cycle on, for exactly CLR_CYC cycles. `sel_in_o` then follows for exactly RUNUP_CYC cycles.
- R3: No two of `int_clr_o`, `sel_in_o` and `sel_ref_o` are ever high in the same cycle.
- R4: `sel_ref_o` rises in the cycle right after the last run-up cycle. It stays high until the run-down phase ends.
- R5: `cmp_i` high means the integrator has reached zero. It passes through two synchronizing flops, and only a low-to-high transition of the synchronized value ends run-down. If `cmp_i` goes high D cycles after the first `sel_ref_o` cycle, with D+2 <= 2*RUNUP_CYC, then `result_o` = D+2 and `sel_ref_o` is high for D+3 cycles.
- R6: If no synchronized rising edge has been seen when the run-down count reaches 2*RUNUP_CYC, run-down ends after 2*RUNUP_CYC+1 cycles with `result_o` = 2*RUNUP_CYC and `ovr_o` = 1.
- R7: `valid_o` is high for exactly one cycle, the cycle right after the last `sel_ref_o` cycle. In the following cycle every output control is low again (idle).
- R8: A start pulse while a conversion is in progress is ignored: the phase lengths and the result of that conversion are unchanged.
- R9: A synchronized edge that arrives at count 2*RUNUP_CYC exactly gives `result_o` = 2*RUNUP_CYC with `ovr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-conversion pulse, honoured only when idle |
| cmp_i | input | 1 | Asynchronous comparator output, high once the integrator is back at zero |
| int_clr_o | output | 1 | Integrator clear switch control |
| sel_in_o | output | 1 | Unknown-input switch control (run-up) |
| sel_ref_o | output | 1 | Reference switch control (run-down) |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| ovr_o | output | 1 | Overrange flag, meaningful with `valid_o` |
| result_o | output | $clog2(2*RUNUP_CYC+1) | Run-down cycle count |

## Verification
The comparator delay is swept over every cycle from the first run-down cycle up to past the overrange limit. Each delay value is its own analog input level. The sweep separates three cases: normal counts, where the count must equal the delay plus the synchronizer latency; an edge landing exactly on the limit, which must still count as a normal result; and the overrange outcomes. One further case never raises the comparator, which isolates the saturation path. Runs that pulse start during run-up and run-down show whether a busy sequencer ignores the request, because the phase lengths and the result must not change.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLR   = 3'd1,
    ST_RUNUP = 3'd2,
    ST_RUNDN = 3'd3,
    ST_DONE  = 3'd4
  } dsadc_st_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], async_i};
  end

  // R5: the synchronized level is sh_q[STAGES-1]; the extra flop holds its previous value for edge detection
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dsadc_cnt.sv
module dsadc_cnt #(
  parameter int CNT_W = 6,
  parameter int LIMIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6: the phase counter never runs past the saturation limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LIMIT));
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
  import dsadc_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int CLR_CYC   = 4,
  parameter int RUNUP_CYC = 16,
  parameter int MAX_CNT   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output dsadc_st_e        state_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             load_o,
  output logic             ovr_set_o
);
  dsadc_st_e state_q, state_d;
  logic      at_max;

  assign at_max = (cnt_i == CNT_W'(MAX_CNT));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CLR;
      ST_CLR:   if (cnt_i == CNT_W'(CLR_CYC - 1)) state_d = ST_RUNUP;
      ST_RUNUP: if (cnt_i == CNT_W'(RUNUP_CYC - 1)) state_d = ST_RUNDN;
      ST_RUNDN: if (rise_i || at_max) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign cnt_clr_o = (state_d != state_q);
  assign cnt_en_o  = (state_q == ST_CLR) || (state_q == ST_RUNUP) || (state_q == ST_RUNDN);
  assign load_o    = (state_q == ST_RUNDN) && (rise_i || at_max);
  // R9: an edge at the limit takes priority over overrange
  assign ovr_set_o = (state_q == ST_RUNDN) && !rise_i && at_max;

  // R8: the clear phase is entered only from idle
  a_r8_clr_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_CLR) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RUNUP_CYC   = 16,
  parameter int CLR_CYC     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_CNT    = 2 * RUNUP_CYC,
  localparam int RES_W      = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             int_clr_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic             valid_o,
  output logic             ovr_o,
  output logic [RES_W-1:0] result_o
);
  localparam int LIMIT = (CLR_CYC > MAX_CNT) ? CLR_CYC : MAX_CNT;
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic             rise;
  logic             cnt_clr, cnt_en, load, ovr_set;
  logic [CNT_W-1:0] cnt;
  dsadc_st_e        state;
  logic [RES_W-1:0] result_q;
  logic             ovr_q;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cmp_i), .rise_o(rise)
  );

  dsadc_cnt #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en), .cnt_o(cnt)
  );

  dsadc_fsm #(
    .CNT_W(CNT_W), .CLR_CYC(CLR_CYC), .RUNUP_CYC(RUNUP_CYC), .MAX_CNT(MAX_CNT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rise_i(rise), .cnt_i(cnt),
    .state_o(state), .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en),
    .load_o(load), .ovr_set_o(ovr_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ovr_q    <= 1'b0;
    end else if (load) begin
      result_q <= RES_W'(cnt);
      ovr_q    <= ovr_set;
    end
  end

  assign int_clr_o = (state == ST_CLR);
  assign sel_in_o  = (state == ST_RUNUP);
  assign sel_ref_o = (state == ST_RUNDN);
  assign valid_o   = (state == ST_DONE);
  assign ovr_o     = valid_o & ovr_q;
  assign result_o  = result_q;

  // R2: run-up always follows the clear phase
  a_r2_runup_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_in_o) |-> $past(int_clr_o));
  // R4: the reference is switched in straight after run-up
  a_r4_ref_after_runup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref_o) |-> $past(sel_in_o));
  // R7: valid is a single-cycle strobe following run-down
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r7_valid_after_rundown: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(sel_ref_o));
  // R6: overrange carries the saturated count
  a_r6_ovr_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (result_o == RES_W'(MAX_CNT)));
endmodule

// File: tb/test_dsadc_seq.sv
module test_dsadc_seq;
  localparam int RUNUP = 8;
  localparam int CLR   = 3;
  localparam int MAXC  = 2 * RUNUP;
  localparam int RW    = $clog2(MAXC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_i = 1'b0;
  logic          int_clr_o, sel_in_o, sel_ref_o, valid_o, ovr_o;
  logic [RW-1:0] result_o;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  dsadc_seq #(.RUNUP_CYC(RUNUP), .CLR_CYC(CLR)) i_dsadc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .int_clr_o(int_clr_o), .sel_in_o(sel_in_o), .sel_ref_o(sel_ref_o),
    .valid_o(valid_o), .ovr_o(ovr_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic all_low(input string req);
    chk(int_clr_o == 0, req, "int_clr_o", int'(int_clr_o), 0);
    chk(sel_in_o == 0,  req, "sel_in_o",  int'(sel_in_o), 0);
    chk(sel_ref_o == 0, req, "sel_ref_o", int'(sel_ref_o), 0);
    chk(valid_o == 0,   req, "valid_o",   int'(valid_o), 0);
    chk(ovr_o == 0,     req, "ovr_o",     int'(ovr_o), 0);
  endtask

  // d: cycles after the first reference cycle at which the comparator goes high
  task automatic conv(input int d, input bit poke);
    int clr_n = 0, in_n = 0, ref_n = 0, guard = 0, overlap = 0;
    bit got = 0, prev_ref = 0, adj = 0;
    int res = 0, ov = 0, exp_res, exp_ov, exp_ref;
    @(negedge clk);
    start_i = 1'b1;
    while (!got && guard < 400) begin
      @(negedge clk);
      start_i = 1'b0;
      guard++;
      if (int'(int_clr_o) + int'(sel_in_o) + int'(sel_ref_o) > 1) overlap++;
      if (int_clr_o) clr_n++;
      if (sel_in_o) begin
        in_n++;
        if (poke && in_n == 3) start_i = 1'b1;
      end
      if (sel_ref_o) begin
        if (ref_n == d) cmp_i = 1'b1;
        if (poke && ref_n == 1) start_i = 1'b1;
        ref_n++;
      end
      if (valid_o) begin
        got = 1;
        adj = prev_ref;
        res = int'(result_o);
        ov = int'(ovr_o);
      end
      prev_ref = sel_ref_o;
    end
    start_i = 1'b0;
    if (d + 2 <= MAXC) begin
      exp_res = d + 2; exp_ov = 0; exp_ref = d + 3;
    end else begin
      exp_res = MAXC; exp_ov = 1; exp_ref = MAXC + 1;
    end
    chk(got, "R7", "valid seen", int'(got), 1);
    chk(adj, "R7", "valid right after run-down", int'(adj), 1);
    chk(overlap == 0, "R3", "overlapping controls", overlap, 0);
    chk(clr_n == CLR, poke ? "R8" : "R2", "clear cycles", clr_n, CLR);
    chk(in_n == RUNUP, poke ? "R8" : "R2", "run-up cycles", in_n, RUNUP);
    chk(ref_n == exp_ref, "R4", "reference cycles", ref_n, exp_ref);
    if (d + 2 == MAXC)
      chk(res == exp_res && ov == 0, "R9", "edge at limit result", res, exp_res);
    else if (exp_ov == 1)
      chk(res == exp_res, "R6", "saturated result", res, exp_res);
    else
      chk(res == exp_res, poke ? "R8" : "R5", "result", res, exp_res);
    chk(ov == exp_ov, exp_ov ? "R6" : "R5", "overrange flag", ov, exp_ov);
    @(negedge clk);
    cmp_i = 1'b0;
    all_low("R7");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    all_low("R1");
    chk(result_o == 0, "R1", "result in reset", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    all_low("R1");
    chk(result_o == 0, "R1", "result after reset", int'(result_o), 0);
    for (int d = 0; d <= MAXC; d++) conv(d, 1'b0);
    conv(1000, 1'b0);
    conv(5, 1'b1);
    conv(MAXC - 2, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule